// File: doc/BRIEF.md
# Auxiliary Video Pulse Decoder

This block sits beside a television sync generator. The sync generator owns the line and tick counters. This block receives four inputs from it: the current line number, the tick position inside the line, the index of the field within a four-field sequence, and a three-bit system code. From these it decodes the auxiliary timing pulses that a video source needs besides composite sync:

- horizontal drive and clamp, on every line;
- a burst gate that turns into a chroma-blanking gate in SECAM, with burst suppressed on line ranges that depend on the field;
- a white-measurement strobe, driven only inside its line windows;
- an identification pulse on its own line windows.

Tick 0 is the leading edge of composite sync. A line is 320 ticks long.

The block also holds the half-line-rate PAL phase flag. The flag inverts at the start of every line. A rising edge on the set-identification input inverts it once more, so an outside source can put the PAL phase sequence back in step. Every output is registered. Each output reflects the inputs that were present one clock earlier.

Top module: `aux_pulse_gen`

## Requirements
- R1: While `rst` is high, at every clock edge, all pulse outputs, `wmp_oe_o` and `pal_sw_o` are cleared to 0.
- R2: `hd_o` is high exactly for ticks 4 to 39 of every line, in every system.
- R3: `clp_o` is high exactly for ticks 8 to 19 of every line.
- R4: For the PAL and NTSC systems (codes 1, 2, 3, 5, 6, 7), `bk_o` is high for ticks 28 to 39, except on burst-suppressed lines, where it stays low.
- R5: For PAL B/G (code 5) and PAL-N (code 1), burst is suppressed as follows, with wrap past the last line: field index 0 on lines 623..6, index 1 on 310..318, index 2 on 622..5, index 3 on 311..319.
- R6: For NTSC (codes 2, 6, 7), burst is suppressed on lines 523..6 for even field index and on lines 261..269 for odd field index. For PAL-M (code 3), burst is suppressed by field index 0..3 on lines 523..8, 260..270, 522..7 and 259..269.
- R7: For SECAM (codes 0 and 4), `bk_o` acts as chroma blanking and is high for ticks 8 to 43. In code 0 it is held low on the identification lines 7..15 and 320..328.
- R8: `wmp_oe_o` and `wmp_o` are high only for ticks 172 to 183 on the white-measurement lines. For 625-line codes (0, 1, 4, 5) these are lines 163..173 and 475..485. For the other codes they are 134..143 and 396..405. At all other times both outputs are low, which means high impedance.
- R9: `id_o` is high for ticks 8 to 67 on lines 7..15 and 320..328 for 625-line codes, and on lines 8..22 and 271..285 for the other codes.
- R10: `pal_sw_o` inverts after every clock in which the tick is 0. A rising edge of `set_id_i` inverts it once more, so tick 0 together with a rising edge leaves it unchanged. A held level of `set_id_i` has no effect.
- R11: Code 7 behaves as NTSC, including the 525-line windows and the NTSC suppression lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_i | input | 3 | System code: 0 SECAM-1, 1 PAL-N, 2 NTSC-1, 3 PAL-M, 4 SECAM-2, 5 PAL B/G, 6 NTSC-2, 7 as NTSC |
| field_i | input | 2 | Field index 0..3 within the four-field sequence |
| line_i | input | 10 | Line number, counted from 1 |
| tick_i | input | 9 | Tick within the line, 0 = composite-sync leading edge |
| set_id_i | input | 1 | Set identification; the rising edge corrects the PAL phase |
| bk_o | output | 1 | Burst gate, or chroma blanking in SECAM |
| clp_o | output | 1 | Clamp pulse |
| hd_o | output | 1 | Horizontal drive |
| wmp_o | output | 1 | White-measurement level, valid while enabled |
| wmp_oe_o | output | 1 | White-measurement drive enable |
| id_o | output | 1 | Identification pulse |
| pal_sw_o | output | 1 | Half-line-rate PAL phase flag |

## Verification
One line is swept tick by tick so that the edges of drive, clamp and burst are each seen one tick before, on and after their boundaries. The burst-suppression tests step through each field index, using the lines just outside and on each range end, including the ranges that wrap past line 1. This separates the PAL, PAL-M and NTSC tables from each other and from a table that ignores the field index. The white-measurement and identification tests use the first and last window lines and their neighbours, in both 625-line and 525-line codes. This exposes a wrong line-count family or a wrong window end. The phase-flag test tells tick-0 toggling apart from set-identification edges, held levels, and the case where both happen together.

// File: rtl/aux_pulse_pkg.sv
package aux_pulse_pkg;

  typedef enum logic [2:0] {
    SYS_SECAM1 = 3'd0,
    SYS_PALN   = 3'd1,
    SYS_NTSC1  = 3'd2,
    SYS_PALM   = 3'd3,
    SYS_SECAM2 = 3'd4,
    SYS_PALBG  = 3'd5,
    SYS_NTSC2  = 3'd6,
    SYS_SPARE  = 3'd7
  } sys_code_e;

  typedef enum logic [1:0] {
    FAM_SECAM,
    FAM_PAL,
    FAM_PALM,
    FAM_NTSC
  } sys_family_e;

  function automatic sys_family_e family_of(input logic [2:0] code);
    case (code)
      SYS_SECAM1, SYS_SECAM2: family_of = FAM_SECAM;
      SYS_PALN,   SYS_PALBG:  family_of = FAM_PAL;
      SYS_PALM:               family_of = FAM_PALM;
      default:                family_of = FAM_NTSC;
    endcase
  endfunction

  // Line range test; lo > hi means the range wraps through line 1.
  function automatic logic in_span(input int ln, input int lo, input int hi);
    if (lo <= hi) in_span = (ln >= lo) && (ln <= hi);
    else          in_span = (ln >= lo) || (ln <= hi);
  endfunction

endpackage

// File: rtl/aux_tick_window.sv
module aux_tick_window #(
  parameter int TICK_W = 9,
  parameter int START  = 0,
  parameter int WIDTH  = 1
) (
  input  logic [TICK_W-1:0] tick_i,
  output logic              hit_o
);
  localparam logic [TICK_W-1:0] LO = TICK_W'(START);
  localparam logic [TICK_W-1:0] HI = TICK_W'(START + WIDTH - 1);

  assign hit_o = (tick_i >= LO) && (tick_i <= HI);
endmodule

// File: rtl/aux_line_decode.sv
module aux_line_decode
  import aux_pulse_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic [2:0]        sys_i,
  input  logic [1:0]        field_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              secam_o,
  output logic              supp_o,
  output logic              wmp_line_o,
  output logic              id_line_o,
  output logic              cb_gap_o
);
  sys_family_e fam;
  int          ln;
  logic        lines625;

  assign fam      = family_of(sys_i);
  assign ln       = int'(line_i);
  assign lines625 = (fam == FAM_SECAM) || (fam == FAM_PAL);
  assign secam_o  = (fam == FAM_SECAM);

  always_comb begin
    supp_o = 1'b0;
    case (fam)
      FAM_PAL: begin
        case (field_i)
          2'd0: supp_o = in_span(ln, 623, 6);
          2'd1: supp_o = in_span(ln, 310, 318);
          2'd2: supp_o = in_span(ln, 622, 5);
          default: supp_o = in_span(ln, 311, 319);
        endcase
      end
      FAM_PALM: begin
        case (field_i)
          2'd0: supp_o = in_span(ln, 523, 8);
          2'd1: supp_o = in_span(ln, 260, 270);
          2'd2: supp_o = in_span(ln, 522, 7);
          default: supp_o = in_span(ln, 259, 269);
        endcase
      end
      FAM_NTSC: begin
        if (field_i[0]) supp_o = in_span(ln, 261, 269);
        else            supp_o = in_span(ln, 523, 6);
      end
      default: supp_o = 1'b0;
    endcase
  end

  always_comb begin
    if (lines625) begin
      wmp_line_o = in_span(ln, 163, 173) || in_span(ln, 475, 485);
      id_line_o  = in_span(ln, 7, 15)    || in_span(ln, 320, 328);
    end else begin
      wmp_line_o = in_span(ln, 134, 143) || in_span(ln, 396, 405);
      id_line_o  = in_span(ln, 8, 22)    || in_span(ln, 271, 285);
    end
  end

  assign cb_gap_o = (sys_i == SYS_SECAM1) && id_line_o;
endmodule

// File: rtl/aux_pal_phase.sv
module aux_pal_phase (
  input  logic clk,
  input  logic rst,
  input  logic line_start_i,
  input  logic set_id_i,
  output logic sw_o
);
  logic sid_q;
  logic sid_rise;
  logic sw_q;

  assign sid_rise = set_id_i && !sid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sid_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      sid_q <= set_id_i;
      sw_q  <= sw_q ^ line_start_i ^ sid_rise;
    end
  end

  assign sw_o = sw_q;

  p_line_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    (line_start_i && !sid_rise) |=> (sw_q != $past(sw_q)));
endmodule

// File: rtl/aux_pulse_gen.sv
module aux_pulse_gen #(
  parameter int LINE_W    = 10,
  parameter int TICK_W    = 9,
  parameter int HD_START  = 4,
  parameter int HD_WIDTH  = 36,
  parameter int CLP_START = 8,
  parameter int CLP_WIDTH = 12,
  parameter int BK_START  = 28,
  parameter int BK_WIDTH  = 12,
  parameter int CB_START  = 8,
  parameter int CB_WIDTH  = 36,
  parameter int WMP_START = 172,
  parameter int WMP_WIDTH = 12,
  parameter int ID_START  = 8,
  parameter int ID_WIDTH  = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sys_i,
  input  logic [1:0]        field_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              set_id_i,
  output logic              bk_o,
  output logic              clp_o,
  output logic              hd_o,
  output logic              wmp_o,
  output logic              wmp_oe_o,
  output logic              id_o,
  output logic              pal_sw_o
);
  localparam int NWIN = 6;
  localparam int WIN_START [NWIN] = '{HD_START, CLP_START, BK_START, CB_START, WMP_START, ID_START};
  localparam int WIN_WIDTH [NWIN] = '{HD_WIDTH, CLP_WIDTH, BK_WIDTH, CB_WIDTH, WMP_WIDTH, ID_WIDTH};
  localparam int W_HD = 0, W_CLP = 1, W_BK = 2, W_CB = 3, W_WMP = 4, W_ID = 5;

  logic [NWIN-1:0] hit;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    aux_tick_window #(
      .TICK_W(TICK_W), .START(WIN_START[g]), .WIDTH(WIN_WIDTH[g])
    ) u_win (
      .tick_i(tick_i),
      .hit_o (hit[g])
    );
  end

  logic secam, supp, wmp_line, id_line, cb_gap;

  aux_line_decode #(.LINE_W(LINE_W)) u_dec (
    .sys_i     (sys_i),
    .field_i   (field_i),
    .line_i    (line_i),
    .secam_o   (secam),
    .supp_o    (supp),
    .wmp_line_o(wmp_line),
    .id_line_o (id_line),
    .cb_gap_o  (cb_gap)
  );

  aux_pal_phase u_phase (
    .clk         (clk),
    .rst         (rst),
    .line_start_i(tick_i == '0),
    .set_id_i    (set_id_i),
    .sw_o        (pal_sw_o)
  );

  logic bk_d;
  assign bk_d = secam ? (hit[W_CB] && !cb_gap) : (hit[W_BK] && !supp);

  logic bk_q, clp_q, hd_q, wmp_q, id_q, secam_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bk_q    <= 1'b0;
      clp_q   <= 1'b0;
      hd_q    <= 1'b0;
      wmp_q   <= 1'b0;
      id_q    <= 1'b0;
      secam_q <= 1'b0;
    end else begin
      bk_q    <= bk_d;
      clp_q   <= hit[W_CLP];
      hd_q    <= hit[W_HD];
      wmp_q   <= hit[W_WMP] && wmp_line;
      id_q    <= hit[W_ID] && id_line;
      secam_q <= secam;
    end
  end

  assign bk_o     = bk_q;
  assign clp_o    = clp_q;
  assign hd_o     = hd_q;
  assign wmp_o    = wmp_q;
  assign wmp_oe_o = wmp_q;
  assign id_o     = id_q;

  p_clp_in_hd_r3: assert property (@(posedge clk) disable iff (rst)
    clp_o |-> hd_o);
  p_burst_in_hd_r4: assert property (@(posedge clk) disable iff (rst)
    (bk_o && !secam_q) |-> hd_o);
  p_hd_not_wmp_r2: assert property (@(posedge clk) disable iff (rst)
    hd_o |-> !wmp_oe_o);
  p_wmp_id_apart_r8: assert property (@(posedge clk) disable iff (rst)
    wmp_oe_o |-> !id_o);
endmodule

// File: tb/test_aux_pulse_gen.sv
module test_aux_pulse_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sys = 3'd5;
  logic [1:0] fld = 2'd0;
  logic [9:0] line = 10'd100;
  logic [8:0] tick = 9'd100;
  logic       sid = 1'b0;
  logic bk, clp, hd, wmp, wmp_oe, id, psw;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aux_pulse_gen i_aux_pulse_gen (
    .clk(clk), .rst(rst), .sys_i(sys), .field_i(fld), .line_i(line),
    .tick_i(tick), .set_id_i(sid), .bk_o(bk), .clp_o(clp), .hd_o(hd),
    .wmp_o(wmp), .wmp_oe_o(wmp_oe), .id_o(id), .pal_sw_o(psw)
  );

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (sys=%0d fld=%0d line=%0d tick=%0d)",
               req, what, got, exp, sys, fld, line, tick);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic apply(input int s, input int f, input int ln, input int tk);
    sys = 3'(s); fld = 2'(f); line = 10'(ln); tick = 9'(tk);
    @(negedge clk);
  endtask

  function automatic bit span(input int ln, input int lo, input int hi);
    return (lo <= hi) ? (ln >= lo && ln <= hi) : (ln >= lo || ln <= hi);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check("R1", "bk",  bk, 0);   check("R1", "clp", clp, 0);
    check("R1", "hd",  hd, 0);   check("R1", "wmp_oe", wmp_oe, 0);
    check("R1", "id",  id, 0);   check("R1", "pal_sw", psw, 0);
    rst = 1'b0;
  endtask

  task automatic t_line_sweep;
    for (int t = 0; t < 320; t++) begin
      apply(5, 0, 100, t);
      check("R2", "hd", hd, (t >= 4 && t <= 39));
      check("R3", "clp", clp, (t >= 8 && t <= 19));
      check("R4", "bk", bk, (t >= 28 && t <= 39));
      check("R8", "wmp_oe off-window", wmp_oe, 0);
      check("R9", "id off-window", id, 0);
    end
    for (int t = 0; t < 60; t++) begin
      apply(2, 1, 50, t);
      check("R2", "hd ntsc", hd, (t >= 4 && t <= 39));
      check("R4", "bk ntsc", bk, (t >= 28 && t <= 39));
    end
  endtask

  task automatic supp_case(input string req, input int s, input int f, input int lo, input int hi);
    int pts[6] = '{lo - 1, lo, hi, hi + 1, (lo > hi) ? 1 : lo + 1, (lo > hi) ? 625 - 100 : hi - 1};
    for (int k = 0; k < 6; k++) begin
      int ln = pts[k];
      if (ln < 1) ln = 1;
      apply(s, f, ln, 30);
      check(req, "bk suppression", bk, !span(ln, lo, hi));
    end
  endtask

  task automatic t_pal_supp;
    supp_case("R5", 5, 0, 623, 6);
    supp_case("R5", 5, 1, 310, 318);
    supp_case("R5", 1, 2, 622, 5);
    supp_case("R5", 1, 3, 311, 319);
  endtask

  task automatic t_ntsc_palm_supp;
    supp_case("R6", 2, 0, 523, 6);
    supp_case("R6", 6, 1, 261, 269);
    supp_case("R6", 2, 2, 523, 6);
    supp_case("R6", 2, 3, 261, 269);
    supp_case("R6", 3, 0, 523, 8);
    supp_case("R6", 3, 1, 260, 270);
    supp_case("R6", 3, 2, 522, 7);
    supp_case("R6", 3, 3, 259, 269);
  endtask

  task automatic t_secam;
    for (int t = 0; t < 60; t++) begin
      apply(4, 0, 100, t);
      check("R7", "chroma blank", bk, (t >= 8 && t <= 43));
    end
    apply(0, 0, 315, 20); check("R7", "secam1 normal line", bk, 1);
    apply(0, 0, 10, 20);  check("R7", "secam1 id line", bk, 0);
    apply(0, 1, 320, 20); check("R7", "secam1 id line 320", bk, 0);
    apply(0, 1, 329, 20); check("R7", "secam1 after id", bk, 1);
    apply(4, 0, 10, 20);  check("R7", "secam2 id line", bk, 1);
    apply(4, 0, 623, 20); check("R7", "secam no suppression", bk, 1);
  endtask

  task automatic t_wmp;
    int l625[8] = '{162, 163, 173, 174, 474, 475, 485, 486};
    int l525[8] = '{133, 134, 143, 144, 395, 396, 405, 406};
    for (int k = 0; k < 8; k++) begin
      apply(5, 0, l625[k], 175);
      check("R8", "wmp_oe 625", wmp_oe, span(l625[k], 163, 173) || span(l625[k], 475, 485));
      check("R8", "wmp 625", wmp, span(l625[k], 163, 173) || span(l625[k], 475, 485));
      apply(3, 0, l525[k], 175);
      check("R8", "wmp_oe 525", wmp_oe, span(l525[k], 134, 143) || span(l525[k], 396, 405));
    end
    apply(0, 0, 165, 171); check("R8", "wmp before", wmp_oe, 0);
    apply(0, 0, 165, 172); check("R8", "wmp first tick", wmp_oe, 1);
    apply(0, 0, 165, 183); check("R8", "wmp last tick", wmp_oe, 1);
    apply(0, 0, 165, 184); check("R8", "wmp after", wmp_oe, 0); check("R8", "wmp level", wmp, 0);
  endtask

  task automatic t_id;
    int l625[8] = '{6, 7, 15, 16, 319, 320, 328, 329};
    int l525[8] = '{7, 8, 22, 23, 270, 271, 285, 286};
    for (int k = 0; k < 8; k++) begin
      apply(1, 0, l625[k], 40);
      check("R9", "id 625", id, span(l625[k], 7, 15) || span(l625[k], 320, 328));
      apply(6, 0, l525[k], 40);
      check("R9", "id 525", id, span(l525[k], 8, 22) || span(l525[k], 271, 285));
    end
    apply(5, 0, 10, 7);  check("R9", "id before", id, 0);
    apply(5, 0, 10, 8);  check("R9", "id first", id, 1);
    apply(5, 0, 10, 67); check("R9", "id last", id, 1);
    apply(5, 0, 10, 68); check("R9", "id after", id, 0);
  endtask

  task automatic t_phase;
    logic base;
    apply(5, 0, 100, 5);
    base = psw;
    apply(5, 0, 100, 6); check("R10", "no tick0 hold", psw, base);
    apply(5, 0, 100, 0); check("R10", "tick0 toggle", psw, !base);
    apply(5, 0, 100, 1); check("R10", "steady", psw, !base);
    sid = 1'b1;
    apply(5, 0, 100, 2); check("R10", "set_id rise", psw, base);
    apply(5, 0, 100, 3); check("R10", "set_id held 1", psw, base);
    apply(5, 0, 100, 4); check("R10", "set_id held 2", psw, base);
    sid = 1'b0;
    apply(5, 0, 100, 5); check("R10", "set_id fall", psw, base);
    sid = 1'b1;
    apply(5, 0, 100, 0); check("R10", "tick0 with rise cancel", psw, base);
    sid = 1'b0;
    apply(5, 0, 100, 0); check("R10", "tick0 toggle again", psw, !base);
  endtask

  task automatic t_spare_code;
    apply(7, 1, 262, 30); check("R11", "code7 suppress 261..269", bk, 0);
    apply(7, 0, 262, 30); check("R11", "code7 even field burst", bk, 1);
    apply(7, 0, 140, 175); check("R11", "code7 wmp 525 window", wmp_oe, 1);
    apply(7, 0, 170, 175); check("R11", "code7 no 625 window", wmp_oe, 0);
    apply(7, 0, 20, 40);  check("R11", "code7 id 525", id, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_line_sweep;
    t_pal_supp;
    t_ntsc_palm_supp;
    t_secam;
    t_wmp;
    t_id;
    t_phase;
    t_spare_code;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule